// File: doc/BRIEF.md
# Vector Float Sign Extractor

This block takes a vector of up to four single-precision floating-point words and replaces each word with the sign of its value. The result is one of three constants: zero, plus one or minus one. The decision looks only at the bit pattern. The zero status comes from the 31 bits below the sign bit, and the polarity comes from bit 31. No floating-point arithmetic is done, so NaN and infinity get no special handling.

A count input selects how many lanes the operation covers, starting from lane 0. Lanes outside that count are copied to the output unchanged. The result is held in one register stage. It appears one clock after an input strobe, together with a one-cycle output strobe. Lane i occupies bits [32*i+31 : 32*i] of both data buses.

Top module: `vsign_extract`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0 and out_data is all zeros until the first accepted input.
- R2: An active lane holding 32'h00000000 or 32'h80000000 produces 32'h00000000.
- R3: An active lane with bit 31 clear and a nonzero value in bits 30:0 produces 32'h3F800000 (+1.0).
- R4: An active lane with bit 31 set and a nonzero value in bits 30:0 produces 32'hBF800000 (-1.0).
- R5: Infinity and NaN patterns follow the sign-bit rule alone. For example, 32'h7F800000 and 32'h7FC00001 give 32'h3F800000, and 32'hFF800000 and 32'hFFC00000 give 32'hBF800000.
- R6: in_count selects the active lanes as follows: 2'b00 selects lane 0, 2'b01 selects lanes 0-1, 2'b10 selects lanes 0-2 and 2'b11 selects all four lanes.
- R7: A lane whose index is greater than the value of in_count is copied from in_data to out_data bit for bit.
- R8: out_valid is 1 in the cycle after each cycle with in_valid high and is 0 otherwise. Back-to-back inputs give back-to-back results.
- R9: While in_valid is low, out_data keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe, one vector per high cycle |
| in_count | input | 2 | Active lane count minus one |
| in_data | input | 128 | Four 32-bit lanes, lane 0 in the low bits |
| out_valid | output | 1 | Result strobe |
| out_data | output | 128 | Four 32-bit result lanes |

## Verification
Every result, whether for an active lane or a copied one, lands in the single output register. It becomes visible at the first rising edge after in_valid was sampled high. The bench drives inputs on falling edges and reads out_data and out_valid on the next falling edge, which falls exactly one register stage after the input. One falling edge later it checks that out_valid has dropped again, and when no new input has been given it also checks that out_data is unchanged. The bound checker covers the same one-cycle relation from every input cycle to the following cycle.

// File: rtl/vsign_pkg.sv
package vsign_pkg;
   localparam int unsigned FP_W = 32;
   localparam logic [FP_W-1:0] FP_ZERO    = 32'h0000_0000;
   localparam logic [FP_W-1:0] FP_POS_ONE = 32'h3F80_0000;
   localparam logic [FP_W-1:0] FP_NEG_ONE = 32'hBF80_0000;

   typedef enum logic [1:0] {
      SGN_ZERO = 2'd0,
      SGN_POS  = 2'd1,
      SGN_NEG  = 2'd2
   } sgn_class_e;

   function automatic logic [FP_W-1:0] sgn_encode(input sgn_class_e c);
      case (c)
         SGN_POS: return FP_POS_ONE;
         SGN_NEG: return FP_NEG_ONE;
         default: return FP_ZERO;
      endcase
   endfunction
endpackage

// File: rtl/vsign_lane_mask.sv
module vsign_lane_mask #(
   parameter int unsigned LANES = 4,
   parameter int unsigned CNT_W = 2
) (
   input  logic [CNT_W-1:0] count,
   output logic [LANES-1:0] active
);
   for (genvar g = 0; g < LANES; g++) begin : g_cmp
      assign active[g] = ({1'b0, CNT_W'(g)} <= {1'b0, count});
   end
endmodule

// File: rtl/vsign_lane.sv
module vsign_lane
   import vsign_pkg::*;
#(
   parameter int unsigned WORD_W = 32
) (
   input  logic              active,
   input  logic [WORD_W-1:0] word_in,
   output logic [WORD_W-1:0] word_out
);
   sgn_class_e cls;
   logic       mag_zero;

   always_comb begin
      mag_zero = (word_in[WORD_W-2:0] == '0);
      if (mag_zero)                cls = SGN_ZERO;
      else if (word_in[WORD_W-1])  cls = SGN_NEG;
      else                         cls = SGN_POS;
   end

   assign word_out = active ? sgn_encode(cls) : word_in;
endmodule

// File: rtl/vsign_extract.sv
module vsign_extract
   import vsign_pkg::*;
#(
   parameter int unsigned LANES  = 4,
   parameter int unsigned WORD_W = 32,
   localparam int unsigned CNT_W = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int unsigned BUS_W = LANES * WORD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [CNT_W-1:0] in_count,
   input  logic [BUS_W-1:0] in_data,
   output logic             out_valid,
   output logic [BUS_W-1:0] out_data
);
   if (WORD_W != FP_W) begin : g_bad_word
      $error("vsign_extract: WORD_W must be 32 for single precision");
   end
   if (LANES < 1 || LANES > 8) begin : g_bad_lanes
      $error("vsign_extract: LANES must lie in 1..8");
   end

   logic [LANES-1:0] lane_active;
   logic [BUS_W-1:0] lane_result;

   vsign_lane_mask #(.LANES(LANES), .CNT_W(CNT_W)) u_mask (
      .count  (in_count),
      .active (lane_active)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      vsign_lane #(.WORD_W(WORD_W)) u_lane (
         .active   (lane_active[g]),
         .word_in  (in_data[g*WORD_W +: WORD_W]),
         .word_out (lane_result[g*WORD_W +: WORD_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= lane_result;
      end
   end
endmodule

// File: rtl/vsign_extract_chk.sv
module vsign_extract_chk #(
   parameter int unsigned LANES  = 4,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned CNT_W  = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic [CNT_W-1:0]        in_count,
   input logic [LANES*WORD_W-1:0] in_data,
   input logic                    out_valid,
   input logic [LANES*WORD_W-1:0] out_data
);
   a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      a_r2_zero: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && ({1'b0, CNT_W'(g)} <= {1'b0, in_count})
         && in_data[g*WORD_W +: WORD_W-1] == '0
         |=> out_data[g*WORD_W +: WORD_W] == 32'h0000_0000);
      a_r3_pos: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && ({1'b0, CNT_W'(g)} <= {1'b0, in_count})
         && !in_data[g*WORD_W+WORD_W-1] && in_data[g*WORD_W +: WORD_W-1] != '0
         |=> out_data[g*WORD_W +: WORD_W] == 32'h3F80_0000);
      a_r4_neg: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && ({1'b0, CNT_W'(g)} <= {1'b0, in_count})
         && in_data[g*WORD_W+WORD_W-1] && in_data[g*WORD_W +: WORD_W-1] != '0
         |=> out_data[g*WORD_W +: WORD_W] == 32'hBF80_0000);
      a_r7_copy: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && ({1'b0, CNT_W'(g)} > {1'b0, in_count})
         |=> out_data[g*WORD_W +: WORD_W] == $past(in_data[g*WORD_W +: WORD_W]));
   end
endmodule

bind vsign_extract vsign_extract_chk #(.LANES(LANES), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_count(in_count),
   .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/vsign_extract_test.sv
module vsign_extract_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   in_count = 2'b00;
   logic [127:0] in_data = '0;
   logic         out_valid;
   logic [127:0] out_data;

   int n_chk = 0;
   int n_bad = 0;
   logic [127:0] last_out = '0;

   vsign_extract uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_count(in_count),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
   );

   always #5 clk = ~clk;

   function automatic logic [31:0] sgn_of(input logic [31:0] w);
      if (w[30:0] == 31'd0) return 32'h0000_0000;
      if (w[31])            return 32'hBF80_0000;
      return 32'h3F80_0000;
   endfunction

   function automatic logic [127:0] model(input logic [1:0] cnt, input logic [127:0] d);
      logic [127:0] r;
      for (int i = 0; i < 4; i++)
         r[i*32 +: 32] = (i <= int'(cnt)) ? sgn_of(d[i*32 +: 32]) : d[i*32 +: 32];
      return r;
   endfunction

   task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // one vector in, result sampled one register stage later, strobe dropped after
   task automatic run_vec(input string req, input logic [1:0] cnt, input logic [127:0] d);
      logic [127:0] exp;
      exp = model(cnt, d);
      @(negedge clk);
      in_valid = 1'b1; in_count = cnt; in_data = d;
      @(negedge clk);
      in_valid = 1'b0; in_data = ~d;
      chk({req, " valid R8"}, {127'd0, out_valid}, 128'd1);
      chk(req, out_data, exp);
      @(negedge clk);
      chk({req, " strobe low R8"}, {127'd0, out_valid}, 128'd0);
      chk({req, " hold R9"}, out_data, exp);
      last_out = exp;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 valid in reset", {127'd0, out_valid}, 128'd0);
      chk("R1 data in reset", out_data, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R1 valid after reset", {127'd0, out_valid}, 128'd0);
      chk("R1 data after reset", out_data, 128'd0);
   endtask

   task automatic t_zeros();
      run_vec("R2 signed zeros", 2'b11,
              {32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 32'h0000_0000});
   endtask

   task automatic t_pos();
      run_vec("R3 positives", 2'b11,
              {32'h0000_0001, 32'h3F80_0000, 32'h4120_0000, 32'h7F7F_FFFF});
   endtask

   task automatic t_neg();
      run_vec("R4 negatives", 2'b11,
              {32'h8000_0001, 32'hBF80_0000, 32'hC2C8_0000, 32'hFFFF_FFFF});
   endtask

   task automatic t_special();
      run_vec("R5 inf nan", 2'b11,
              {32'hFFC0_0000, 32'hFF80_0000, 32'h7FC0_0001, 32'h7F80_0000});
   endtask

   task automatic t_counts();
      logic [127:0] d;
      d = {32'h8000_0000, 32'hC000_0000, 32'h4000_0000, 32'h8000_0000};
      for (int c = 0; c < 4; c++) begin
         run_vec("R6 R7 lane count", 2'(c), d);
      end
      run_vec("R7 copy odd words", 2'b00,
              {32'h1234_5678, 32'hDEAD_BEEF, 32'h0000_0000, 32'h7F80_0000});
   endtask

   task automatic t_hold();
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         in_count = 2'(i); in_data = {4{32'h5A5A_A5A5}} ^ 128'(i);
      end
      @(negedge clk);
      chk("R9 idle hold", out_data, last_out);
      chk("R8 idle no strobe", {127'd0, out_valid}, 128'd0);
   endtask

   task automatic t_b2b();
      logic [127:0] d0, d1;
      d0 = {32'h0000_0000, 32'h8000_0005, 32'h0000_0007, 32'hFFFF_0000};
      d1 = {32'h3F00_0000, 32'h0000_0000, 32'h8000_0000, 32'h0000_0009};
      @(negedge clk);
      in_valid = 1'b1; in_count = 2'b11; in_data = d0;
      @(negedge clk);
      chk("R8 first of pair", {127'd0, out_valid}, 128'd1);
      chk("R8 first data", out_data, model(2'b11, d0));
      in_count = 2'b01; in_data = d1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 second of pair", {127'd0, out_valid}, 128'd1);
      chk("R8 second data", out_data, model(2'b01, d1));
      @(negedge clk);
      chk("R8 pair ends", {127'd0, out_valid}, 128'd0);
      last_out = model(2'b01, d1);
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_zeros();
      t_pos();
      t_neg();
      t_special();
      t_counts();
      t_hold();
      t_b2b();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule